// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller with Byte Lanes

This block sits between an internal single-word request port and an external asynchronous static RAM of 64K words by 16 bits that has a separate active-low strobe per byte lane. It turns each request into a sequence of registered, active-low pin strobes: chip select, write strobe, output enable and one lane strobe per byte. It also drives a split data bus made of a data-out vector, a data-in vector and a drive-enable. How many clock cycles each phase lasts is worked out at elaboration. The inputs are the clock period and the memory's timing limits in nanoseconds. Every count is rounded up to whole cycles.

A requester raises `req` together with the direction, address, write data and lane mask. It holds them until the controller takes the request, which it does only when idle. Exactly one `ack` pulse follows. On a read, `rdata` is valid from the `ack` cycle on. A write holds chip select, write strobe and the chosen lane strobes low together for the full write window. Output enable stays high throughout, and the data driver is kept off until the memory's output turn-off time has passed. A read holds chip select, output enable and the lane strobes low long enough for the slowest access path, then captures the data.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request: memCeN, memWeN, memOeN and both memLaneN bits are 1, dataOe is 0 and ack is 0.
- R2: A write with a nonzero lane mask holds memCeN, memWeN and the selected memLaneN bits low together for exactly WR_CYC cycles (2 at default parameters), starting the cycle after acceptance. All of them rise on the same edge, and memOeN stays 1 for the whole write.
- R3: During a write, dataOe is 0 in the first TURN_CYC cycles of the write window (1 at defaults) and 1 afterwards. It stays 1 for exactly one cycle after memWeN rises and is then 0. dataOut carries the request's write data whenever dataOe is 1.
- R4: A read with a nonzero lane mask holds memCeN, memOeN and the selected memLaneN bits low with memWeN at 1 for exactly RD_CYC cycles (2 at defaults). The data bus is sampled on the edge that ends that window.
- R5: Lane mask bit 0 controls memLaneN[0] and data bits 7:0, and bit 1 controls memLaneN[1] and bits 15:8. A lane whose mask bit is 0 keeps its strobe at 1 and is not written, and on a read it returns 0 in rdata.
- R6: A request with lane mask 00 is acknowledged in the cycle after acceptance. No strobe falls and the driver stays off.
- R7: Each accepted request produces exactly one ack cycle. It comes after WR_CYC+1 cycles for a write, RD_CYC+1 cycles for a read and 1 cycle for an empty mask. On reads, rdata in that cycle equals the enabled lanes of the addressed word.
- R8: memAddr equals the request address for the whole time memCeN is low and does not change while memCeN stays low.
- R9: dataOe is never 1 while memOeN is 0, or in the cycle after memOeN was 0.
- R10: In the ack cycle and while idle, memCeN is 1, both memLaneN bits are 1 and memOeN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid, sampled only when idle |
| reqWe | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| memAddr | output | 16 | Memory address pins |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memLaneN | output | 2 | Byte lane strobes, active low |
| dataOut | output | 16 | Data toward memory |
| dataOe | output | 1 | Drive enable for dataOut |
| dataIn | input | 16 | Data from memory |

## Verification
The bench pursues four corner cases:
- Single-lane writes must merge into an existing word. A design that wired the lane strobes the wrong way round, or wrote the full word, would corrupt the neighbouring byte on the next full read.
- Reads must be sampled no earlier than the access window allows. The memory model returns junk until the data is valid, so a controller that sampled one cycle early would return junk.
- The driver must stay off in the turn-off window after the write strobe falls, and also right after a read. A driver enabled too early shows up as a contention or a turn-on mismatch.
- An empty lane mask must produce an ack with no strobe activity. A design that still pulsed the strobes, or never acknowledged, is caught by the cycle-by-cycle pin comparison.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WPULSE = 3'd1,
    ST_WEND   = 3'd2,
    ST_RACC   = 3'd3,
    ST_REND   = 3'd4,
    ST_NACK   = 3'd5
  } seqState_t;

  // Strobe bundle from sequencer to pin datapath (active-high meanings)
  typedef struct packed {
    logic chipOn;
    logic writeOn;
    logic readOn;
    logic laneOn;
    logic drvOn;
    logic load;
    logic capture;
    logic ackOn;
  } pinCmd_t;

  function automatic int unsigned ceilDiv(int unsigned n, int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int WR_CYC   = 2,
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    reqWe,
  input  logic    beAny,
  output pinCmd_t cmd
);

  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_V  = CNT_W'(TURN_CYC);

  seqState_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          if (!beAny)     nextState = ST_NACK;
          else if (reqWe) nextState = ST_WPULSE;
          else            nextState = ST_RACC;
        end
      end
      ST_WPULSE: if (cnt == WR_LAST) nextState = ST_WEND;
      ST_WEND:   nextState = ST_IDLE;
      ST_RACC:   if (cnt == RD_LAST) nextState = ST_REND;
      ST_REND:   nextState = ST_IDLE;
      ST_NACK:   nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    if (nextState != state || nextState == ST_IDLE) nextCnt = '0;
    else                                            nextCnt = cnt + 1'b1;
  end

  // Strobes are decoded from the next state so the datapath can register them
  always_comb begin
    cmd         = '0;
    cmd.chipOn  = (nextState == ST_WPULSE) || (nextState == ST_RACC);
    cmd.writeOn = (nextState == ST_WPULSE);
    cmd.readOn  = (nextState == ST_RACC);
    cmd.laneOn  = cmd.chipOn;
    cmd.drvOn   = ((nextState == ST_WPULSE) && (nextCnt >= TURN_V)) ||
                  (nextState == ST_WEND);
    cmd.load    = (state == ST_IDLE) && req;
    cmd.capture = (state == ST_RACC) && (cnt == RD_LAST);
    cmd.ackOn   = (nextState == ST_WEND) || (nextState == ST_REND) ||
                  (nextState == ST_NACK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  AST_WPULSE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WEND) |-> ($past(state) == ST_WPULSE && $past(cnt) == WR_LAST)); // R2
  AST_RACC_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REND) |-> ($past(state) == ST_RACC && $past(cnt) == RD_LAST)); // R4

endmodule

// File: rtl/sram_pin_path.sv
module sram_pin_path
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter bit HAS_TURN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinCmd_t           cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W/8-1:0] memLaneN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int NLANE = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [NLANE-1:0]  beQ;
  logic [NLANE-1:0]  laneSel;
  logic [DATA_W-1:0] rdataQ;
  logic              ceNQ, weNQ, oeNQ, drvQ, ackQ;
  logic [NLANE-1:0]  laneNQ;

  assign laneSel = cmd.load ? reqBe : beQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      ceNQ   <= 1'b1;
      weNQ   <= 1'b1;
      oeNQ   <= 1'b1;
      laneNQ <= '1;
      drvQ   <= 1'b0;
      ackQ   <= 1'b0;
    end else begin
      if (cmd.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      ceNQ   <= ~cmd.chipOn;
      weNQ   <= ~cmd.writeOn;
      oeNQ   <= ~cmd.readOn;
      laneNQ <= ~(laneSel & {NLANE{cmd.laneOn}});
      drvQ   <= cmd.drvOn;
      ackQ   <= cmd.ackOn;
    end
  end

  // Per-lane read capture with masking of disabled lanes
  for (genvar l = 0; l < NLANE; l++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)            rdataQ[l*8 +: 8] <= '0;
      else if (cmd.capture) rdataQ[l*8 +: 8] <= beQ[l] ? dataIn[l*8 +: 8] : 8'h00;
    end
  end

  assign memAddr  = addrQ;
  assign memCeN   = ceNQ;
  assign memWeN   = weNQ;
  assign memOeN   = oeNQ;
  assign memLaneN = laneNQ;
  assign dataOut  = wdataQ;
  assign dataOe   = drvQ;
  assign ack      = ackQ;
  assign rdata    = rdataQ;

  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R2
  AST_WR_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R2
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> dataOe); // R3
  AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |=> !dataOe); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr)); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> memOeN); // R9
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> !dataOe); // R9
  AST_ACK_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (memCeN && memOeN && (&memLaneN))); // R10

  if (HAS_TURN) begin : gTurnChk
    AST_DRV_WAIT: assert property (@(posedge clk) disable iff (!rstN)
      $fell(memWeN) |-> !dataOe); // R3
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 10,
  parameter int T_WCYC_NS  = 12,
  parameter int T_CEWR_NS  = 9,
  parameter int T_BEWR_NS  = 8,
  parameter int T_ADWR_NS  = 8,
  parameter int T_DSU_NS   = 6,
  parameter int T_TOFF_NS  = 6,
  parameter int T_ACC_NS   = 12,
  parameter int T_OEACC_NS = 6,
  parameter int T_BEACC_NS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                req,
  input  logic                reqWe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                ack,
  output logic [DATA_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memLaneN,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  input  logic [DATA_W-1:0]   dataIn
);

  localparam int TURN_CYC = int'(ceilDiv(T_TOFF_NS, CLK_NS));
  localparam int DSU_CYC  = int'(max2(1, ceilDiv(T_DSU_NS, CLK_NS)));
  localparam int WR_CYC   = int'(max2(max2(ceilDiv(T_WCYC_NS, CLK_NS), ceilDiv(T_CEWR_NS, CLK_NS)),
                                 max2(max2(ceilDiv(T_BEWR_NS, CLK_NS), ceilDiv(T_ADWR_NS, CLK_NS)),
                                      TURN_CYC + DSU_CYC)));
  localparam int RD_CYC   = int'(max2(1, max2(ceilDiv(T_ACC_NS, CLK_NS),
                                 max2(ceilDiv(T_OEACC_NS, CLK_NS), ceilDiv(T_BEACC_NS, CLK_NS)))));
  localparam int CNT_W    = $clog2(int'(max2(WR_CYC, RD_CYC)) + 1);

  pinCmd_t cmd;

  sram_seq_ctrl #(
    .WR_CYC  (WR_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) uSeq (
    .clk  (clk),
    .rstN (rstN),
    .req  (req),
    .reqWe(reqWe),
    .beAny(|reqBe),
    .cmd  (cmd)
  );

  sram_pin_path #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .HAS_TURN(TURN_CYC > 0)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqBe   (reqBe),
    .dataIn  (dataIn),
    .ack     (ack),
    .rdata   (rdata),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memLaneN(memLaneN),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;

  localparam int CLK_PERIOD = 10;
  // Cycle budgets derived in the bench from the nanosecond limits
  localparam int B_TURN = (6 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_WR   = (12 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_RD   = (12 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0, reqWe = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic ack;
  logic [15:0] rdata, memAddr, dataOut;
  logic memCeN, memWeN, memOeN, dataOe;
  logic [1:0] memLaneN;
  logic [15:0] dataIn = 16'hDEAD;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] modelMem [int];
  logic [15:0] shadow   [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl uut (
    .clk(clk), .rstN(rstN), .req(req), .reqWe(reqWe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .ack(ack), .rdata(rdata),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memLaneN(memLaneN), .dataOut(dataOut), .dataOe(dataOe), .dataIn(dataIn)
  );

  // ---------------- behavioural memory model with timing checks ----------
  logic        rdActPrev = 1'b0;
  logic [1:0]  wrPrev = 2'b00;
  logic [15:0] prevData = '0, prevAddr = '0;
  logic        prevDrv = 1'b0;
  int          readAge = 0;

  always @(negedge clk) begin
    logic rdAct;
    logic [1:0] wrAct;
    logic [15:0] word;
    if (rstN) begin
      rdAct = !memCeN && !memOeN && memWeN;
      nChecks++;
      if (dataOe && (rdAct || rdActPrev)) begin
        nFails++;
        $display("FAIL R9 bus contention: dataOe=%0b oeN=%0b prevRead=%0b expected driver off",
                 dataOe, memOeN, rdActPrev);
      end
      for (int l = 0; l < 2; l++) begin
        wrAct[l] = !memCeN && !memWeN && !memLaneN[l];
        if (wrPrev[l] && wrAct[l] && memAddr != prevAddr) begin
          nFails++;
          $display("FAIL R8 address moved during write: got %h expected %h", memAddr, prevAddr);
        end
        if (wrPrev[l] && !wrAct[l]) begin
          nChecks++;
          if (!prevDrv || !dataOe || dataOut[l*8 +: 8] != prevData[l*8 +: 8]) begin
            nFails++;
            $display("FAIL R3 write data setup/hold lane %0d: drvBefore=%0b drvAfter=%0b got %h expected %h",
                     l, prevDrv, dataOe, dataOut[l*8 +: 8], prevData[l*8 +: 8]);
          end
          word = modelMem.exists(int'(prevAddr)) ? modelMem[int'(prevAddr)] : 16'h0000;
          word[l*8 +: 8] = prevData[l*8 +: 8];
          modelMem[int'(prevAddr)] = word;
        end
      end
      readAge = rdAct ? readAge + 1 : 0;
      word = modelMem.exists(int'(memAddr)) ? modelMem[int'(memAddr)] : 16'h0000;
      // Data valid only once the access window (>=12 ns) has elapsed
      if (rdAct && readAge >= B_RD) begin
        dataIn[7:0]  = !memLaneN[0] ? word[7:0]  : 8'h5A;
        dataIn[15:8] = !memLaneN[1] ? word[15:8] : 8'hA5;
      end else begin
        dataIn = 16'hDEAD;
      end
      rdActPrev = rdAct;
      wrPrev    = wrAct;
      prevData  = dataOut;
      prevAddr  = memAddr;
      prevDrv   = dataOe;
    end
  end

  // ---------------- check helpers ----------------
  task automatic chkPins(input string tag, input logic [6:0] exp);
    logic [6:0] got;
    got = {memCeN, memWeN, memOeN, memLaneN, dataOe, ack};
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s pins {ceN,weN,oeN,laneN,oe,ack}: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chkVal(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] laneMask(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  // Called on a negedge; returns on the negedge of the idle cycle after ack
  task automatic runTxn(input logic w, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] b);
    int n;
    logic [15:0] old, expR;
    req = 1'b1; reqWe = w; reqAddr = a; reqWdata = d; reqBe = b;
    @(negedge clk);
    req = 1'b0; reqWdata = 16'h0000; reqAddr = 16'h0000;
    n = (b == 2'b00) ? 0 : (w ? B_WR : B_RD);
    for (int k = 1; k <= n; k++) begin
      if (w) chkPins("R2 R3 R5 write window", {1'b0, 1'b0, 1'b1, ~b, (k - 1 >= B_TURN), 1'b0});
      else   chkPins("R4 R5 read window",     {1'b0, 1'b1, 1'b0, ~b, 1'b0, 1'b0});
      chkVal("R8 address during access", memAddr, a);
      @(negedge clk);
    end
    old  = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    expR = old & laneMask(b);
    if (b == 2'b00) begin
      chkPins("R6 R7 empty mask ack", 7'b111_11_0_1);
    end else if (w) begin
      chkPins("R7 R10 write ack, R3 hold", 7'b111_11_1_1);
      chkVal("R3 dataOut during hold", dataOut, d);
      shadow[int'(a)] = (old & ~laneMask(b)) | (d & laneMask(b));
    end else begin
      chkPins("R7 R10 read ack", 7'b111_11_0_1);
      chkVal("R4 R5 R7 read data", rdata, expR);
    end
    @(negedge clk);
    chkPins("R3 R10 idle after ack", 7'b111_11_0_0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) begin
      @(negedge clk);
      chkPins("R1 during reset", 7'b111_11_0_0);
    end
    rstN = 1'b1;
    @(negedge clk);
    chkPins("R1 after reset", 7'b111_11_0_0);
    @(negedge clk);
    chkPins("R1 idle", 7'b111_11_0_0);

    runTxn(1'b1, 16'h0010, 16'h1234, 2'b11);   // R2 full write
    runTxn(1'b0, 16'h0010, 16'h0000, 2'b11);   // R4 full read
    runTxn(1'b1, 16'h0010, 16'hABCD, 2'b01);   // R5 lower lane only
    runTxn(1'b0, 16'h0010, 16'h0000, 2'b11);   // R5 expect 12CD
    runTxn(1'b1, 16'h0010, 16'h5600, 2'b10);   // R5 upper lane only
    runTxn(1'b0, 16'h0010, 16'h0000, 2'b10);   // R5 lower lane masked to zero
    runTxn(1'b0, 16'h0010, 16'h0000, 2'b01);   // R5 upper lane masked to zero
    runTxn(1'b1, 16'h0010, 16'hFFFF, 2'b00);   // R6 empty write
    runTxn(1'b0, 16'h0010, 16'h0000, 2'b00);   // R6 empty read
    runTxn(1'b0, 16'h0010, 16'h0000, 2'b11);   // R6 word unchanged 56CD
    runTxn(1'b1, 16'h0000, 16'h0F0F, 2'b11);   // address boundary low
    runTxn(1'b1, 16'hFFFF, 16'hF00D, 2'b11);   // address boundary high
    runTxn(1'b0, 16'h0000, 16'h0000, 2'b11);
    runTxn(1'b0, 16'hFFFF, 16'h0000, 2'b11);

    // Mixed traffic, read/write turnarounds (R9)
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      runTxn(lfsr[0], {13'h0100, lfsr[5:3]}, lfsr ^ 16'h3C5A, lfsr[2:1]);
    end
    for (int i = 0; i < 8; i++)
      runTxn(1'b0, {13'h0100, 3'(i)}, 16'h0000, 2'b11);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule